// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation vectors by a weight matrix held inside a ROWS-by-COLS grid of multiply-accumulate cells. Each cell keeps one signed 8-bit weight. Activations travel one cell to the right on every clock. Partial sums travel one cell down on every clock, and each cell adds its own product to the sum that arrives from the cell above. The top row starts every sum from zero. The bottom row hands finished dot products to an output stage. Cells talk only to their right-hand and lower neighbours. No data is broadcast across the grid.

The user presents one aligned activation vector per cycle, with a valid flag. Internal skew registers delay row k by k cycles, so that data enters the grid as a diagonal wavefront. A de-skew stage at the bottom edge delays column j by COLS-1-j cycles, so that all column results of one vector leave on the same cycle. A valid bit runs through a matching pipeline.

A small controller has three states:
- ST_IDLE: nothing is in flight.
- ST_STREAM: vectors are being accepted.
- ST_DRAIN: no new input arrives while partial sums are still flowing out.

It moves between them as follows:
- ST_IDLE goes to ST_STREAM on a valid input.
- ST_STREAM goes to ST_DRAIN on a cycle without one.
- ST_DRAIN goes back to ST_STREAM on a valid input.
- ST_DRAIN goes to ST_IDLE after ROWS+COLS-1 consecutive empty cycles.

Weight rows can be written only in ST_IDLE. This keeps the weights fixed for a whole pass. To run a narrow layer, load zero weights into the unused columns and ignore their outputs.

Top module: `ws_matmul`

## Requirements
- R1: While reset is asserted and after it is released, with no input, `out_valid` is 0 and `out_data` is all zeros.
- R2: For an accepted vector x, output column j equals the sum over k of x[k]·W[k][j] as a signed 32-bit value. Here x[k] is `in_data[8k+7:8k]` and W[k][j] is the stored weight, both signed 8-bit. Column j is `out_data[32j+31:32j]`.
- R3: A write with `wl_en` high and `wl_row`=k stores byte j of `wl_data` (bits 8j+7:8j) as W[k][j]. The write is accepted only when the controller is in ST_IDLE and `in_valid` is low. A write at any other time leaves every weight unchanged.
- R4: A vector presented with `in_valid` high in cycle v appears with `out_valid` high in cycle v+ROWS+COLS-1. All of its columns appear together in that one cycle.
- R5: Vectors presented on back-to-back cycles produce results on back-to-back cycles, in input order, each result exactly once.
- R6: Cycles with `in_valid` low produce no `out_valid` and do not disturb the results of the vectors around them. When the grid is idle, the right-edge activations and bottom-edge sums are zero.
- R7: The controller follows the transitions ST_IDLE→ST_STREAM, ST_STREAM→ST_DRAIN, ST_DRAIN→ST_STREAM and ST_DRAIN→ST_IDLE described above. Let v be the last valid cycle. A weight write in cycle v+ROWS+COLS is ignored, and one in cycle v+ROWS+COLS+1 is accepted.
- R8: Zero activations and zero weights are multiplied and added like any other value, and results stay exact.
- R9: With the weights of the unused columns set to zero (a narrow layer), those columns output zero and the used columns are unaffected.
- R10: A single-term product, with only row 0 weights nonzero, gives x[0]·W[0][j] in each column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wl_en | input | 1 | Weight row write request |
| wl_row | input | $clog2(ROWS) | Grid row to write |
| wl_data | input | COLS*8 | One signed byte per column |
| in_valid | input | 1 | Activation vector present |
| in_data | input | ROWS*8 | Aligned activation vector, one signed byte per row |
| out_valid | output | 1 | Result row present |
| out_data | output | COLS*32 | Aligned column results, signed 32-bit each |

## Verification
The assertions check the following on every cycle:
- A cell's weight stays constant in any cycle where writes are locked out.
- A zero activation passes the incoming partial sum down unchanged.
- The controller never jumps from ST_IDLE to ST_DRAIN, and never reports idle while a valid bit is still in flight.
- The array edges are quiet when idle.
- No result appears while the controller is idle.

The arithmetic of whole dot products, the exact R+C-1 latency with column alignment, ordering under gaps, and the cycle at which weight writes are accepted again after a drain can be shown only by the bench. The bench compares each result against matrix products it computes itself. It uses random and directed cases, including single-term products and narrow layers.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } mm_state_t;
endpackage

// File: rtl/wsmm_cell.sv
module wsmm_cell #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frozen,
    input  logic                 w_we,
    input  logic signed [DW-1:0] w_in,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [AW-1:0] s_in,
    output logic signed [DW-1:0] a_out,
    output logic signed [AW-1:0] s_out
);
    localparam int PW = 2 * DW;

    logic signed [DW-1:0] w_q;
    logic signed [DW-1:0] a_q;
    logic signed [AW-1:0] s_q;
    logic signed [PW-1:0] prod;

    assign prod = a_in * w_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (w_we) begin
            w_q <= w_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            s_q <= '0;
        end else begin
            a_q <= a_in;
            s_q <= s_in + {{(AW-PW){prod[PW-1]}}, prod};
        end
    end

    assign a_out = a_q;
    assign s_out = s_q;

    // R3: the stored weight cannot change while the controller locks writes out
    assert_weight_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(w_q));

    // R8: a zero activation adds nothing, so the sum passes down intact
    assert_zero_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in == '0) |=> (s_out == $past(s_in)));
endmodule

// File: rtl/wsmm_skew.sv
module wsmm_skew #(
    parameter int ROWS = 4,
    parameter int DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROWS*DW-1:0]   x_in,
    output logic [ROWS*DW-1:0]   feed
);
    assign feed[DW-1:0] = x_in[DW-1:0];

    for (genvar k = 1; k < ROWS; k++) begin : g_row
        logic [DW-1:0] dl [0:k-1];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < k; i++) dl[i] <= '0;
            end else begin
                dl[0] <= x_in[k*DW +: DW];
                for (int i = 1; i < k; i++) dl[i] <= dl[i-1];
            end
        end
        assign feed[k*DW +: DW] = dl[k-1];
    end
endmodule

// File: rtl/wsmm_deskew.sv
module wsmm_deskew #(
    parameter int COLS = 4,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COLS*AW-1:0]   s_bot,
    output logic [COLS*AW-1:0]   y
);
    for (genvar j = 0; j < COLS; j++) begin : g_col
        localparam int D = COLS - 1 - j;
        if (D == 0) begin : g_pass
            assign y[j*AW +: AW] = s_bot[j*AW +: AW];
        end else begin : g_delay
            logic [AW-1:0] dl [0:D-1];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < D; i++) dl[i] <= '0;
                end else begin
                    dl[0] <= s_bot[j*AW +: AW];
                    for (int i = 1; i < D; i++) dl[i] <= dl[i-1];
                end
            end
            assign y[j*AW +: AW] = dl[D-1];
        end
    end
endmodule

// File: rtl/wsmm_ctrl.sv
module wsmm_ctrl
    import wsmm_pkg::*;
#(
    parameter int LAT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic wgt_open,
    output logic frozen,
    output logic out_valid
);
    localparam int CW = $clog2(LAT + 1);

    mm_state_t       state, state_nx;
    logic [CW-1:0]   cnt;
    logic [LAT-1:0]  vpipe;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_STREAM;
            ST_STREAM: if (!in_valid) state_nx = ST_DRAIN;
            ST_DRAIN: begin
                if (in_valid)                  state_nx = ST_STREAM;
                else if (cnt == CW'(LAT - 1))  state_nx = ST_IDLE;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            vpipe <= '0;
        end else begin
            cnt   <= (state == ST_DRAIN && !in_valid) ? cnt + 1'b1 : '0;
            vpipe <= (vpipe << 1) | LAT'(in_valid);
        end
    end

    always_comb begin
        wgt_open  = (state == ST_IDLE) && !in_valid;
        frozen    = (state != ST_IDLE);
        out_valid = vpipe[LAT-1];
    end

    // R7: idle is entered only once every valid bit has left the pipeline
    assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (vpipe == '0));

    // R7: there is no path from idle straight to draining
    assert_no_idle_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_DRAIN));

    // R7: the drain counter never runs past the pipeline depth
    assert_drain_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (cnt < CW'(LAT)));
endmodule

// File: rtl/ws_matmul.sv
module ws_matmul #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8,
    parameter int AW   = 32,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wl_en,
    input  logic [RW-1:0]        wl_row,
    input  logic [COLS*DW-1:0]   wl_data,
    input  logic                 in_valid,
    input  logic [ROWS*DW-1:0]   in_data,
    output logic                 out_valid,
    output logic [COLS*AW-1:0]   out_data
);
    localparam int LAT = ROWS + COLS - 1;

    logic                 wgt_open;
    logic                 frozen;
    logic [ROWS*DW-1:0]   x_eff;
    logic [ROWS*DW-1:0]   feed;
    logic [COLS*AW-1:0]   s_bot;
    logic [ROWS*DW-1:0]   a_edge;
    logic [DW-1:0]        a_bus [ROWS][COLS];
    logic [AW-1:0]        s_bus [ROWS][COLS];

    assign x_eff = in_valid ? in_data : '0;

    wsmm_ctrl #(.LAT(LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wgt_open  (wgt_open),
        .frozen    (frozen),
        .out_valid (out_valid)
    );

    wsmm_skew #(.ROWS(ROWS), .DW(DW)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_eff),
        .feed  (feed)
    );

    for (genvar k = 0; k < ROWS; k++) begin : g_r
        for (genvar j = 0; j < COLS; j++) begin : g_c
            logic [DW-1:0] a_src;
            logic [AW-1:0] s_src;
            if (j == 0) begin : g_left
                assign a_src = feed[k*DW +: DW];
            end else begin : g_inner
                assign a_src = a_bus[k][j-1];
            end
            if (k == 0) begin : g_top
                assign s_src = '0;
            end else begin : g_mid
                assign s_src = s_bus[k-1][j];
            end
            wsmm_cell #(.DW(DW), .AW(AW)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .frozen (frozen),
                .w_we   (wgt_open && wl_en && (wl_row == RW'(k))),
                .w_in   (wl_data[j*DW +: DW]),
                .a_in   (a_src),
                .s_in   (s_src),
                .a_out  (a_bus[k][j]),
                .s_out  (s_bus[k][j])
            );
        end
        assign a_edge[k*DW +: DW] = a_bus[k][COLS-1];
    end

    for (genvar j = 0; j < COLS; j++) begin : g_bot
        assign s_bot[j*AW +: AW] = s_bus[ROWS-1][j];
    end

    wsmm_deskew #(.COLS(COLS), .AW(AW)) u_deskew (
        .clk   (clk),
        .rst_n (rst_n),
        .s_bot (s_bot),
        .y     (out_data)
    );

    // R6: an idle grid holds no activations at its right edge and no sums at its bottom
    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |-> (a_edge == '0 && s_bot == '0));

    // R4: a result never emerges while the controller is idle
    assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> frozen);
endmodule

// File: tb/ws_matmul_test.sv
module ws_matmul_test;
    localparam int R   = 4;
    localparam int C   = 4;
    localparam int LAT = R + C - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wl_en = 1'b0;
    logic [1:0]       wl_row = '0;
    logic [C*8-1:0]   wl_data = '0;
    logic             in_valid = 1'b0;
    logic [R*8-1:0]   in_data = '0;
    logic             out_valid;
    logic [C*32-1:0]  out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic signed [7:0] wm [R][C];
    logic [C*32-1:0]   exp_y [$];
    int                exp_c [$];
    string             exp_t [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ws_matmul #(.ROWS(R), .COLS(C)) uut (
        .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .wl_row(wl_row), .wl_data(wl_data),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [C*32-1:0] ref_y(input logic [R*8-1:0] x);
        logic [C*32-1:0] y;
        for (int j = 0; j < C; j++) begin
            int acc = 0;
            for (int k = 0; k < R; k++) begin
                int xa = int'($signed(x[k*8 +: 8]));
                int wa = int'(wm[k][j]);
                acc += xa * wa;
            end
            y[j*32 +: 32] = acc;
        end
        return y;
    endfunction

    function automatic logic [7:0] rnd_byte(input int zero_pct);
        if (($urandom % 100) < zero_pct) return 8'h00;
        return 8'($urandom);
    endfunction

    function automatic logic [R*8-1:0] rnd_vec(input int zero_pct);
        logic [R*8-1:0] v;
        for (int k = 0; k < R; k++) v[k*8 +: 8] = rnd_byte(zero_pct);
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [C*32-1:0] act,
                         input logic [C*32-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick(input bit iv, input logic [R*8-1:0] x, input bit we, input int row,
                        input logic [C*8-1:0] wd, input bit accept, input string tag);
        in_valid = iv;
        in_data  = x;
        wl_en    = we;
        wl_row   = 2'(row);
        wl_data  = wd;
        if (iv) begin
            exp_y.push_back(ref_y(x));
            exp_c.push_back(cyc + LAT);
            exp_t.push_back(tag);
        end
        if (we && accept)
            for (int j = 0; j < C; j++) wm[row][j] = wd[j*8 +: 8];
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, 0, '0, 1'b0, "");
    endtask

    task automatic load_w(input logic [C*8-1:0] rows [R]);
        for (int k = 0; k < R; k++) tick(1'b0, '0, 1'b1, k, rows[k], 1'b1, "R3");
    endtask

    task automatic settle();
        idle(2 * LAT + 4);
    endtask

    // Output monitor: every result is compared with the queued expectation.
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (exp_y.size() == 0) begin
                check(1'b0, "R6 unexpected out_valid", out_data, '0);
            end else begin
                logic [C*32-1:0] e;
                int ec;
                string t;
                e  = exp_y.pop_front();
                ec = exp_c.pop_front();
                t  = exp_t.pop_front();
                check(out_data == e, {t, " R2 data"}, out_data, e);
                if (cyc != ec) begin
                    fails++;
                    $display("FAIL R4 latency actual=%0d expected=%0d", cyc, ec);
                end
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            finish_up();
        end
    end

    initial begin
        logic [C*8-1:0] wr [R];
        int n;
        void'($urandom(32'd20240611));
        for (int k = 0; k < R; k++) for (int j = 0; j < C; j++) wm[k][j] = '0;

        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 in reset", {out_data}, '0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0 && out_data == '0, "R1 after reset", out_data, '0);
        end
        @(posedge clk);
        #1;

        // R2/R4/R5: random weights, back-to-back vectors
        for (int k = 0; k < R; k++) wr[k] = {rnd_byte(0), rnd_byte(0), rnd_byte(0), rnd_byte(0)};
        load_w(wr);
        for (int i = 0; i < 6; i++) tick(1'b1, rnd_vec(10), 1'b0, 0, '0, 1'b0, "R5");
        n = cyc - 1;

        // R7: write in the last drain cycle is ignored, the next one lands
        while (cyc < n + 1 + LAT) tick(1'b0, '0, 1'b0, 0, '0, 1'b0, "");
        tick(1'b0, '0, 1'b1, 0, {4{8'h01}}, 1'b0, "R7");
        tick(1'b0, '0, 1'b1, 1, {8'h05, 8'hF9, 8'h7F, 8'h80}, 1'b1, "R7");
        for (int i = 0; i < 4; i++) tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R7");
        settle();

        // R3: writes while a vector is offered in idle, and mid-stream, are ignored
        tick(1'b1, rnd_vec(0), 1'b1, 2, {4{8'h33}}, 1'b0, "R3");
        tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R3");
        tick(1'b1, rnd_vec(0), 1'b1, 3, {4{8'h44}}, 1'b0, "R3");
        tick(1'b0, '0, 1'b1, 0, {4{8'h55}}, 1'b0, "R3");
        tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R3");
        settle();
        for (int i = 0; i < 3; i++) tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R3");
        settle();

        // R10: single-term products, only row 0 weights nonzero
        wr[0] = {8'h80, 8'h7F, 8'hFF, 8'h03};
        for (int k = 1; k < R; k++) wr[k] = '0;
        load_w(wr);
        for (int i = 0; i < 5; i++) tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R10");
        settle();

        // R9: narrow layer, columns 2 and 3 loaded with zero
        for (int k = 0; k < R; k++) wr[k] = {8'h00, 8'h00, rnd_byte(0), rnd_byte(0)};
        load_w(wr);
        for (int i = 0; i < 5; i++) tick(1'b1, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R9");
        settle();

        // R8: zero operands and extreme values
        for (int k = 0; k < R; k++) wr[k] = {8'h80, 8'h00, 8'h7F, rnd_byte(40)};
        load_w(wr);
        tick(1'b1, '0, 1'b0, 0, '0, 1'b0, "R8");
        tick(1'b1, {4{8'h80}}, 1'b0, 0, '0, 1'b0, "R8");
        tick(1'b1, {8'h00, 8'h7F, 8'h00, 8'h80}, 1'b0, 0, '0, 1'b0, "R8");
        tick(1'b1, rnd_vec(60), 1'b0, 0, '0, 1'b0, "R8");
        settle();

        // R6: random passes with gaps
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < R; k++)
                wr[k] = {rnd_byte(20), rnd_byte(20), rnd_byte(20), rnd_byte(20)};
            load_w(wr);
            for (int i = 0; i < 20; i++) begin
                if (($urandom % 100) < 30) tick(1'b0, rnd_vec(0), 1'b0, 0, '0, 1'b0, "R6");
                else tick(1'b1, rnd_vec(15), 1'b0, 0, '0, 1'b0, "R6");
            end
            settle();
        end

        // R5: every queued result has been delivered exactly once
        checks++;
        if (exp_y.size() != 0) begin
            fails++;
            $display("FAIL R5 pending actual=%0d expected=0", exp_y.size());
        end
        done = 1'b1;
        finish_up();
    end
endmodule